// File: doc/BRIEF.md
# Flash Controller Event and Status Unit

This unit sits beside the command sequencer of a serial flash controller and gathers its eight event pulses into one interrupt line. Each pulse sets a sticky bit in a raw event register. A mask register blocks sources when a bit is 1. Software clears sticky bits by writing ones to a clear register. A masked view of the events feeds a registered, level-sensitive interrupt output.

The same register port also holds three other functions. The first is a self-clearing recovery command that holds the sequencer and FIFO in reset for a fixed number of cycles. The second is a pair of FIFO threshold fields that are driven out to the FIFO. The third is a packed FIFO status word, built from the transmit free-space level and the receive fill level that the FIFO reports. Reads have one cycle of latency: `reg_rdata` shows the register addressed on the previous clock edge.

Top module: `flash_evt_unit`

## Requirements
- R1: After reset the mask register reads 0xFF (all sources blocked). The raw and masked event registers read 0, `irq` is 0, the threshold register reads 0, the recovery register reads 0 and `recov_rst` is 0.
- R2: A 1 on bit i of `evt_in` sets raw bit i on the next edge, whatever the mask holds. The bit assignments are: 0 rx full, 1 rx underflow, 2 tx overflow, 3 tx empty, 4 transfer done, 5 bus error, 6 serial-link error, 7 DMA done. The raw register is at address 0x0.
- R3: Writing to the clear register (address 0x2) clears each raw bit whose write-data bit is 1. Bits written 0 keep their value. The clear register reads 0.
- R4: When an event and a clear hit the same raw bit in the same cycle, the event wins and the bit stays 1.
- R5: The mask register (address 0x1, bits 7:0) is read/write. The masked status (address 0x3) reads raw AND NOT mask.
- R6: `irq` is the registered OR of the masked status bits. It follows the masked status one cycle later.
- R7: Writing 1 to bit 0 of the recovery register (address 0x4) raises `recov_rst` for exactly RECOV_CYCLES cycles. During that time bit 0 reads 1; afterwards it reads 0. A write of 0, or a write made while recovery is already running, does not change the recovery state.
- R8: The FIFO status word (address 0x6) packs four flags and two levels. Bit 0 is tx full (tx free level is 0). Bit 1 is tx empty (tx free level equals FIFO_DEPTH). Bit 2 is rx empty (rx fill level is 0). Bit 3 is rx full (rx fill level equals FIFO_DEPTH). Bits 12:8 hold the tx free level and bits 20:16 hold the rx fill level.
- R9: The threshold register (address 0x5) holds the tx threshold in bits 4:0 and the rx threshold in bits 12:8. Other bits read 0. The two fields drive `tx_thresh` and `rx_thresh`.
- R10: `reg_rdata` presents the register addressed on the previous edge. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_in | input | 8 | Event pulses from the sequencer |
| tx_level | input | 5 | Transmit FIFO free entries |
| rx_level | input | 5 | Receive FIFO filled entries |
| irq | output | 1 | Level interrupt |
| recov_rst | output | 1 | Recovery reset to sequencer and FIFO |
| tx_thresh | output | 5 | Transmit threshold |
| rx_thresh | output | 5 | Receive threshold |

## Verification
An event pulse and a software clear can target the same sticky bit on the same edge. The bench provokes this by driving an event bit together with a clear write that covers that bit and one other set bit. It then expects the event bit to stay set and the other bit to drop. A second overlap is a repeated recovery write that arrives while the recovery window is still open. The bench judges it by counting the cycles `recov_rst` stays high and expecting exactly RECOV_CYCLES.

// File: rtl/flash_evt_pkg.sv
package flash_evt_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;
  localparam int N_EVT   = 8;

  localparam logic [ADDR_W-1:0] A_RAW    = 4'h0;
  localparam logic [ADDR_W-1:0] A_MASK   = 4'h1;
  localparam logic [ADDR_W-1:0] A_CLR    = 4'h2;
  localparam logic [ADDR_W-1:0] A_MASKED = 4'h3;
  localparam logic [ADDR_W-1:0] A_RECOV  = 4'h4;
  localparam logic [ADDR_W-1:0] A_THRESH = 4'h5;
  localparam logic [ADDR_W-1:0] A_FIFO   = 4'h6;

  // threshold field positions
  localparam int TX_TH_LSB = 0;
  localparam int RX_TH_LSB = 8;
  // FIFO status word positions
  localparam int TX_LVL_LSB = 8;
  localparam int RX_LVL_LSB = 16;
endpackage

// File: rtl/flash_evt_latch.sv
module flash_evt_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] masked_o,
  output logic         irq_o
);
  // events have priority over the clear on the same bit
  always_ff @(posedge clk) begin
    if (rst) begin
      raw_o  <= '0;
      mask_o <= '1;
      irq_o  <= 1'b0;
    end else begin
      raw_o <= (raw_o & ~clr_i) | evt_i;
      if (mask_we) mask_o <= mask_wdata;
      irq_o <= |masked_o;
    end
  end

  always_comb masked_o = raw_o & ~mask_o;
endmodule

// File: rtl/flash_recov_seq.sv
module flash_recov_seq #(
  parameter int RECOV_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(RECOV_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RECOV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        cnt_q  <= LOAD;
      end
    end else if (cnt_q == '0) begin
      busy_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/flash_fifo_stat.sv
module flash_fifo_stat #(
  parameter int LVL_W      = 5,
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 32,
  parameter int TX_LSB     = 8,
  parameter int RX_LSB     = 16
) (
  input  logic [LVL_W-1:0]  tx_free_i,
  input  logic [LVL_W-1:0]  rx_fill_i,
  output logic [DATA_W-1:0] stat_o
);
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(FIFO_DEPTH);

  always_comb begin
    stat_o = '0;
    stat_o[0] = (tx_free_i == '0);
    stat_o[1] = (tx_free_i == DEPTH_L);
    stat_o[2] = (rx_fill_i == '0);
    stat_o[3] = (rx_fill_i == DEPTH_L);
    stat_o[TX_LSB +: LVL_W] = tx_free_i;
    stat_o[RX_LSB +: LVL_W] = rx_fill_i;
  end
endmodule

// File: rtl/flash_evt_unit.sv
module flash_evt_unit
  import flash_evt_pkg::*;
#(
  parameter int LVL_W        = 5,
  parameter int FIFO_DEPTH   = 16,
  parameter int RECOV_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_EVT-1:0]  evt_in,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  output logic              irq,
  output logic              recov_rst,
  output logic [LVL_W-1:0]  tx_thresh,
  output logic [LVL_W-1:0]  rx_thresh
);
  logic [N_EVT-1:0]  raw_bits, mask_bits, masked_bits, clr_bits;
  logic              mask_we, recov_start;
  logic [DATA_W-1:0] fifo_word;

  always_comb begin
    mask_we     = reg_wr && (reg_addr == A_MASK);
    clr_bits    = (reg_wr && (reg_addr == A_CLR)) ? reg_wdata[N_EVT-1:0] : '0;
    recov_start = reg_wr && (reg_addr == A_RECOV) && reg_wdata[0];
  end

  flash_evt_latch #(.N(N_EVT)) u_latch (
    .clk(clk), .rst(rst), .evt_i(evt_in), .clr_i(clr_bits),
    .mask_we(mask_we), .mask_wdata(reg_wdata[N_EVT-1:0]),
    .raw_o(raw_bits), .mask_o(mask_bits), .masked_o(masked_bits), .irq_o(irq)
  );

  flash_recov_seq #(.RECOV_CYCLES(RECOV_CYCLES)) u_recov (
    .clk(clk), .rst(rst), .start_i(recov_start), .busy_o(recov_rst)
  );

  flash_fifo_stat #(
    .LVL_W(LVL_W), .FIFO_DEPTH(FIFO_DEPTH), .DATA_W(DATA_W),
    .TX_LSB(TX_LVL_LSB), .RX_LSB(RX_LVL_LSB)
  ) u_fifo (
    .tx_free_i(tx_level), .rx_fill_i(rx_level), .stat_o(fifo_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_thresh <= '0;
      rx_thresh <= '0;
    end else if (reg_wr && (reg_addr == A_THRESH)) begin
      tx_thresh <= reg_wdata[TX_TH_LSB +: LVL_W];
      rx_thresh <= reg_wdata[RX_TH_LSB +: LVL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      case (reg_addr)
        A_RAW:    reg_rdata[N_EVT-1:0] <= raw_bits;
        A_MASK:   reg_rdata[N_EVT-1:0] <= mask_bits;
        A_MASKED: reg_rdata[N_EVT-1:0] <= masked_bits;
        A_RECOV:  reg_rdata[0]         <= recov_rst;
        A_THRESH: begin
          reg_rdata[TX_TH_LSB +: LVL_W] <= tx_thresh;
          reg_rdata[RX_TH_LSB +: LVL_W] <= rx_thresh;
        end
        A_FIFO:   reg_rdata <= fifo_word;
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/flash_evt_unit_chk.sv
module flash_evt_unit_chk
  import flash_evt_pkg::*;
#(
  parameter int RECOV_CYCLES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [N_EVT-1:0]  evt_in,
  input logic [N_EVT-1:0]  raw_bits,
  input logic [N_EVT-1:0]  mask_bits,
  input logic              irq,
  input logic              recov_rst
);
  logic [N_EVT-1:0] wclr;
  logic             wrec;
  logic [15:0]      hi_cnt;

  always_comb begin
    wclr = (reg_wr && reg_addr == A_CLR) ? reg_wdata[N_EVT-1:0] : '0;
    wrec = reg_wr && reg_addr == A_RECOV && reg_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (recov_rst) hi_cnt <= hi_cnt + 1'b1;
    else hi_cnt <= '0;
  end

  // R2
  evt_sets_raw_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_in) |=> ((raw_bits & $past(evt_in)) == $past(evt_in)));

  // R3
  clr_drops_raw_chk: assert property (@(posedge clk) disable iff (rst)
    (|(wclr & ~evt_in)) |=> ((raw_bits & $past(wclr & ~evt_in)) == '0));

  // R6
  irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (irq == $past(|(raw_bits & ~mask_bits))));

  // R7
  recov_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(recov_rst) |-> $past(wrec));

  // R7
  recov_len_chk: assert property (@(posedge clk) disable iff (rst)
    hi_cnt <= 16'(RECOV_CYCLES));
endmodule

bind flash_evt_unit flash_evt_unit_chk #(.RECOV_CYCLES(RECOV_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .evt_in(evt_in), .raw_bits(raw_bits),
  .mask_bits(mask_bits), .irq(irq), .recov_rst(recov_rst)
);

// File: tb/flash_evt_unit_bench.sv
module flash_evt_unit_bench;
  localparam int LVL_W = 5;
  localparam int DEPTH = 16;
  localparam int RCY   = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  evt_in = '0;
  logic [4:0]  tx_level = '0;
  logic [4:0]  rx_level = '0;
  logic        irq, recov_rst;
  logic [4:0]  tx_thresh, rx_thresh;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_evt_unit #(.LVL_W(LVL_W), .FIFO_DEPTH(DEPTH), .RECOV_CYCLES(RCY)) u_flash_evt_unit (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .tx_level(tx_level), .rx_level(rx_level), .irq(irq),
    .recov_rst(recov_rst), .tx_thresh(tx_thresh), .rx_thresh(rx_thresh)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk);
    evt_in = e;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h1, d); chk("R1 mask", d, 32'hFF);
    rd(4'h0, d); chk("R1 raw", d, 0);
    rd(4'h3, d); chk("R1 masked", d, 0);
    rd(4'h5, d); chk("R1 thresh", d, 0);
    rd(4'h4, d); chk("R1 recov", d, 0);
    chk("R1 irq/recov_rst", {irq, recov_rst}, 0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    logic [7:0] acc = '0;
    for (int i = 0; i < 8; i++) begin
      pulse(8'(1 << i));
      acc |= 8'(1 << i);
      rd(4'h0, d); chk("R2 raw walk", d, {24'h0, acc});
    end
    rd(4'h3, d); chk("R5 masked all blocked", d, 0);
    chk("R6 irq blocked", irq, 0);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(4'h2, 32'h0000_007E);
    rd(4'h0, d); chk("R3 partial clear", d, 32'h81);
    wr(4'h2, 32'h0);
    rd(4'h0, d); chk("R3 zero write", d, 32'h81);
    rd(4'h2, d); chk("R3 clear reads zero", d, 0);
    wr(4'h2, 32'hFF);
    rd(4'h0, d); chk("R3 full clear", d, 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse(8'h08);
    @(negedge clk);
    evt_in = 8'h10; reg_wr = 1'b1; reg_addr = 4'h2; reg_wdata = 32'h18;
    @(negedge clk);
    evt_in = '0; reg_wr = 1'b0;
    rd(4'h0, d); chk("R4 event beats clear", d, 32'h10);
  endtask

  task automatic t_mask_irq();
    logic [31:0] d;
    wr(4'h1, 32'hEF);
    rd(4'h1, d); chk("R5 mask readback", d, 32'hEF);
    rd(4'h3, d); chk("R5 masked view", d, 32'h10);
    chk("R6 irq raised", irq, 1);
    wr(4'h1, 32'hFF);
    @(negedge clk);
    chk("R6 irq dropped by mask", irq, 0);
    wr(4'h1, 32'h00);
    wr(4'h2, 32'hFF);
    @(negedge clk);
    chk("R6 irq dropped by clear", irq, 0);
    wr(4'h1, 32'hFF);
  endtask

  task automatic t_recov();
    logic [31:0] d;
    int n;
    wr(4'h4, 32'h0);
    chk("R7 zero write idle", recov_rst, 0);
    wr(4'h4, 32'h1);
    rd(4'h4, d); chk("R7 reads busy", d, 1);
    repeat (2 * RCY) @(negedge clk);
    rd(4'h4, d); chk("R7 self clear", d, 0);
    // measure length with a second write part way through
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'h4; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr = 1'b0;
    n = 0;
    while (recov_rst && n < 100) begin
      n++;
      if (n == 3) begin reg_wr = 1'b1; reg_addr = 4'h4; reg_wdata = 32'h1; end
      else reg_wr = 1'b0;
      @(negedge clk);
    end
    reg_wr = 1'b0;
    chk("R7 window length with retrigger", n, RCY);
  endtask

  task automatic t_fifo();
    logic [31:0] d;
    tx_level = 5'(DEPTH); rx_level = 0;
    rd(4'h6, d); chk("R8 both empty", d, 32'h0000_1006);
    tx_level = 0; rx_level = 5'(DEPTH);
    rd(4'h6, d); chk("R8 both full", d, 32'h0010_0009);
    tx_level = 5; rx_level = 7;
    rd(4'h6, d); chk("R8 partial", d, 32'h0007_0500);
  endtask

  task automatic t_thresh();
    logic [31:0] d;
    wr(4'h5, 32'hFFFF_EAF3);
    rd(4'h5, d); chk("R9 thresh readback", d, 32'h0A13);
    chk("R9 tx_thresh", tx_thresh, 5'h13);
    chk("R9 rx_thresh", rx_thresh, 5'h0A);
    rd(4'hF, d); chk("R10 unused address", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_events();
    t_clear();
    t_collide();
    t_mask_irq();
    t_recov();
    t_fifo();
    t_thresh();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule